// File: doc/BRIEF.md
# Character Output Device Controller

This block sits beside the execute stage of a 12-bit accumulator processor. It handles the input/output transfer instructions aimed at one character output device, and it holds that device's control and status word. Each cycle it takes an instruction word with a valid strobe, the accumulator and the incremented program counter. From these it works out the next control word and a skip-adjusted program counter. It raises an illegal-instruction flag when a transfer instruction names a device or function that the block does not support.

The control word packs the outgoing byte into its low eight bits. Bit 8 marks a character as waiting (busy) and bit 9 marks the device as ready. A load stores the accumulator's low byte with its top bit inverted, and sets busy. While busy is set, the byte is offered on a valid/ready port to an external transmitter. When the transmitter takes the byte, busy clears and ready sets. A program polls ready with a skip instruction.

Top module: `tty_out_iot`

## Requirements
- R1: An instruction addresses this device only when `instr_valid` is high, the opcode (bits 11..9) is 6 and the device field (bits 8..3) is octal 04. With opcode 6 and any other device code, `illegal` is high and the control word does not change. Any other opcode is ignored: `illegal` stays low, the PC passes through unchanged and the control word keeps its value.
- R2: Function code 0 (bits 2..0) sets the control word to 0x600 on the next clock.
- R3: Function code 1 leaves the control word as it is. When bit 9 is set, it adds one to the low 12 bits of the PC, wrapping at 12 bits, and keeps the bits above bit 11. Otherwise the PC passes through unchanged.
- R4: Function code 2 clears the control word to zero on the next clock.
- R5: Function code 4 keeps bits 11..9 of the control word. Bits 7..0 become the accumulator's bits 7..0 XOR 0x80, and bit 8 is set.
- R6: Function code 6 keeps only bit 11 of the control word. Bits 7..0 become the accumulator's bits 7..0 XOR 0x80, bit 8 is set, and bits 10..9 are cleared.
- R7: Function codes 3, 5 and 7 raise `illegal` and do not change the control word.
- R8: `chr_valid` equals control bit 8, and `chr_data` equals control bits 7..0.
- R9: When `chr_valid` and `chr_ready` are both high and no instruction writes the control word, the next control word has bit 8 clear and bit 9 set. All other bits keep their values.
- R10: When a writing function (0, 2, 4 or 6) and a handshake fall in the same cycle, the result is the one the instruction alone gives.
- R11: While `rst_n` is low, the control word is zero, so `chr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 12 | Instruction word |
| acc | input | 12 | Accumulator value |
| pc_in | input | 15 | Next program counter before any skip |
| pc_out | output | 15 | Next program counter after the skip |
| illegal | output | 1 | Unsupported device or function code |
| ctl | output | 12 | Current control/status word |
| chr_data | output | 8 | Byte offered to the transmitter |
| chr_valid | output | 1 | Byte is waiting |
| chr_ready | input | 1 | Transmitter takes the byte |

## Verification
Assertions check on every clock the following:
- The handshake sets ready and clears busy.
- Function 0 gives 0x600, function 2 gives zero, and function 4 keeps the top field and loads the inverted byte.
- An illegal instruction with no handshake pending leaves the control word stable.
- `illegal` never fires for a non-transfer opcode.
- The PC's upper bits always pass through.

Only the bench's scenarios can show the following:
- The wrap of the low 12 PC bits at 0xFFF.
- The difference between the two load widths after a 0x600 preset.
- An instruction winning over a handshake in the same cycle.
- A byte being held steady while the transmitter stalls.

// File: rtl/tty_iot_pkg.sv
package tty_iot_pkg;

    localparam logic [2:0] OPC_IOT = 3'd6;

    localparam int BUSY_BIT  = 8;
    localparam int READY_BIT = 9;
    localparam int AUX_BIT   = 10;

    localparam int SHORT_CLR_TOP = 8;
    localparam int LONG_CLR_TOP  = 10;

    typedef enum logic [2:0] {
        FN_PRESET   = 3'd0,
        FN_TEST     = 3'd1,
        FN_CLEAR    = 3'd2,
        FN_BAD3     = 3'd3,
        FN_LOAD_S   = 3'd4,
        FN_BAD5     = 3'd5,
        FN_LOAD_L   = 3'd6,
        FN_BAD7     = 3'd7
    } fn_e;

    typedef struct packed {
        logic hit;
        logic illegal;
        logic wr;
        logic test;
        fn_e  fn;
    } dec_t;

endpackage

// File: rtl/tty_iot_decode.sv
module tty_iot_decode
    import tty_iot_pkg::*;
#(
    parameter int         INSN_W   = 12,
    parameter logic [5:0] DEV_CODE = 6'o04
) (
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr,
    output dec_t              dec
);
    localparam int OPC_LSB = INSN_W - 3;

    logic       is_iot;
    logic       dev_hit;
    fn_e        fn;

    always_comb begin
        is_iot  = instr_valid && (instr[INSN_W-1:OPC_LSB] == OPC_IOT);
        dev_hit = (instr[8:3] == DEV_CODE);
        fn      = fn_e'(instr[2:0]);

        dec         = '0;
        dec.fn      = fn;
        dec.hit     = is_iot && dev_hit;
        dec.illegal = is_iot && !dev_hit;
        if (is_iot && dev_hit) begin
            unique case (fn)
                FN_PRESET, FN_CLEAR, FN_LOAD_S, FN_LOAD_L: dec.wr = 1'b1;
                FN_TEST:                                   dec.test = 1'b1;
                default:                                   dec.illegal = 1'b1;
            endcase
        end
    end

    // R7: a rejected instruction never writes the control word
    always_comb begin
        a_excl_r7: assert (!(dec.illegal && dec.wr));
    end

endmodule

// File: rtl/tty_iot_skip.sv
module tty_iot_skip #(
    parameter int PC_W  = 15,
    parameter int LOW_W = 12
) (
    input  logic [PC_W-1:0] pc_in,
    input  logic            do_skip,
    output logic [PC_W-1:0] pc_out
);
    logic [LOW_W-1:0] low_d;

    always_comb begin
        low_d = pc_in[LOW_W-1:0] + LOW_W'(do_skip);
    end

    generate
        if (PC_W > LOW_W) begin : g_bank
            always_comb pc_out = {pc_in[PC_W-1:LOW_W], low_d};
            // R3: the bits above the 12-bit field are never touched
            always_comb begin
                a_bank_r3: assert (pc_out[PC_W-1:LOW_W] == pc_in[PC_W-1:LOW_W]);
            end
        end else begin : g_flat
            always_comb pc_out = low_d;
        end
    endgenerate

endmodule

// File: rtl/tty_iot_ctl_next.sv
module tty_iot_ctl_next
    import tty_iot_pkg::*;
#(
    parameter int CTL_W = 12,
    parameter int ACC_W = 12,
    parameter int CHR_W = 8
) (
    input  logic [CTL_W-1:0] ctl_q,
    input  dec_t             dec,
    input  logic [ACC_W-1:0] acc,
    input  logic             chr_ready,
    output logic [CTL_W-1:0] ctl_d
);
    localparam logic [CTL_W-1:0] PRESET_VAL = CTL_W'((1 << READY_BIT) | (1 << AUX_BIT));
    localparam logic [CTL_W-1:0] KEEP_S     = ~CTL_W'((1 << (SHORT_CLR_TOP + 1)) - 1);
    localparam logic [CTL_W-1:0] KEEP_L     = ~CTL_W'((1 << (LONG_CLR_TOP + 1)) - 1);
    localparam logic [CHR_W-1:0] FLIP       = CHR_W'(1 << (CHR_W - 1));

    logic [CTL_W-1:0] load_bits;
    logic             hs;

    always_comb begin
        load_bits = CTL_W'(acc[CHR_W-1:0] ^ FLIP) | CTL_W'(1 << BUSY_BIT);
        hs        = ctl_q[BUSY_BIT] && chr_ready;

        ctl_d = ctl_q;
        if (hs) begin
            ctl_d[BUSY_BIT]  = 1'b0;
            ctl_d[READY_BIT] = 1'b1;
        end
        if (dec.wr) begin
            unique case (dec.fn)
                FN_PRESET: ctl_d = PRESET_VAL;
                FN_CLEAR:  ctl_d = '0;
                FN_LOAD_S: ctl_d = (ctl_q & KEEP_S) | load_bits;
                FN_LOAD_L: ctl_d = (ctl_q & KEEP_L) | load_bits;
                default:   ctl_d = ctl_q;
            endcase
        end
    end

endmodule

// File: rtl/tty_out_iot.sv
module tty_out_iot
    import tty_iot_pkg::*;
#(
    parameter int         INSN_W   = 12,
    parameter int         ACC_W    = 12,
    parameter int         PC_W     = 15,
    parameter int         CTL_W    = 12,
    parameter int         CHR_W    = 8,
    parameter logic [5:0] DEV_CODE = 6'o04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr,
    input  logic [ACC_W-1:0]  acc,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic              illegal,
    output logic [CTL_W-1:0]  ctl,
    output logic [CHR_W-1:0]  chr_data,
    output logic              chr_valid,
    input  logic              chr_ready
);
    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } state_t;

    state_t state_d, state_q;
    dec_t   dec;
    logic   do_skip;
    logic [CTL_W-1:0] ctl_nx;

    tty_iot_decode #(.INSN_W(INSN_W), .DEV_CODE(DEV_CODE)) i_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec)
    );

    tty_iot_ctl_next #(.CTL_W(CTL_W), .ACC_W(ACC_W), .CHR_W(CHR_W)) i_nx (
        .ctl_q     (state_q.ctl),
        .dec       (dec),
        .acc       (acc),
        .chr_ready (chr_ready),
        .ctl_d     (ctl_nx)
    );

    tty_iot_skip #(.PC_W(PC_W), .LOW_W(12)) i_skip (
        .pc_in   (pc_in),
        .do_skip (do_skip),
        .pc_out  (pc_out)
    );

    always_comb begin
        do_skip     = dec.test && state_q.ctl[READY_BIT];
        state_d     = state_q;
        state_d.ctl = ctl_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign illegal   = dec.illegal;
    assign ctl       = state_q.ctl;
    assign chr_data  = state_q.ctl[CHR_W-1:0];
    assign chr_valid = state_q.ctl[BUSY_BIT];

    p_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && chr_ready && !dec.wr) |=> (ctl[READY_BIT] && !ctl[BUSY_BIT]));

    p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr && dec.fn == FN_PRESET) |=> (ctl == CTL_W'(12'h600)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr && dec.fn == FN_CLEAR) |=> (ctl == '0));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr && dec.fn == FN_LOAD_S) |=>
        (chr_valid && chr_data == ($past(acc[CHR_W-1:0]) ^ CHR_W'(1 << (CHR_W - 1)))
         && ctl[CTL_W-1:READY_BIT] == $past(ctl[CTL_W-1:READY_BIT])));

    p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !chr_valid) |=> $stable(ctl));

    p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[INSN_W-1:INSN_W-3] != OPC_IOT) |-> !illegal);

endmodule

// File: tb/test_tty_out_iot.sv
`timescale 1ns/1ps
module test_tty_out_iot;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] acc = '0;
    logic [14:0] pc_in = '0;
    logic [14:0] pc_out;
    logic        illegal;
    logic [11:0] ctl;
    logic [7:0]  chr_data;
    logic        chr_valid;
    logic        chr_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int m_ctl = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    tty_out_iot i_tty_out_iot (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .acc(acc), .pc_in(pc_in), .pc_out(pc_out), .illegal(illegal),
        .ctl(ctl), .chr_data(chr_data), .chr_valid(chr_valid), .chr_ready(chr_ready)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int oct_iot(int fn, int dev = 4);
        return (6 << 9) | (dev << 3) | fn;
    endfunction

    // One cycle: drive at negedge, check comb outputs, advance model, check ctl after edge.
    task automatic step(string req, bit v, int ins, int a, int pc, bit rdy);
        int opc, dev, fn, e_pc, e_ill, nx;
        bit mine, wr;
        @(negedge clk);
        instr_valid = v; instr = 12'(ins); acc = 12'(a); pc_in = 15'(pc); chr_ready = rdy;
        #0.5;
        opc = (ins >> 9) & 7; dev = (ins >> 3) & 63; fn = ins & 7;
        mine = v && opc == 6 && dev == 4;
        e_ill = (v && opc == 6 && !mine) || (mine && (fn == 3 || fn == 5 || fn == 7));
        e_pc = pc;
        if (mine && fn == 1 && ((m_ctl >> 9) & 1))
            e_pc = (pc & 32'h7000) | ((pc + 1) & 32'hFFF);
        chk({req, " illegal/R1"}, illegal, e_ill);
        chk({req, " pc/R3"}, pc_out, e_pc);
        chk("R8 valid", chr_valid, (m_ctl >> 8) & 1);
        chk("R8 data", chr_data, m_ctl & 255);
        nx = m_ctl;
        if (((m_ctl >> 8) & 1) && rdy) nx = (nx & ~32'h100) | 32'h200;
        wr = mine && (fn == 0 || fn == 2 || fn == 4 || fn == 6);
        if (wr) begin
            case (fn)
                0: nx = 32'h600;
                2: nx = 0;
                4: nx = (m_ctl & 32'hE00) | ((a & 255) ^ 128) | 32'h100;
                default: nx = (m_ctl & 32'h800) | ((a & 255) ^ 128) | 32'h100;
            endcase
        end
        m_ctl = nx;
        @(posedge clk);
        #0.5;
        chk({req, " ctl"}, ctl, m_ctl);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        chk("R11 reset ctl", ctl, 0);
        chk("R11 reset valid", chr_valid, 0);
        @(negedge clk); rst_n = 1'b1;

        step("R1 idle", 0, oct_iot(0), 0, 12'o100, 0);
        step("R3 no skip when not ready", 1, oct_iot(1), 0, 12'o200, 0);
        step("R2 preset", 1, oct_iot(0), 0, 12'o201, 0);
        step("R3 skip wrap", 1, oct_iot(1), 0, 15'h5FFF, 0);
        step("R3 skip mid", 1, oct_iot(1), 0, 15'h2123, 0);
        step("R5 short load keeps 10..9", 1, oct_iot(4), 12'o7101, 0, 0);
        step("R8 stall", 0, 0, 0, 0, 0);
        step("R8 stall", 0, 0, 0, 0, 0);
        step("R9 accept", 0, 0, 0, 0, 1);
        step("R2 preset", 1, oct_iot(0), 0, 0, 0);
        step("R6 long load clears 10..9", 1, oct_iot(6), 12'h0FF, 0, 0);
        step("R3 skip while busy not ready", 1, oct_iot(1), 0, 12'o777, 1);
        step("R1 foreign opcode ignored", 1, 12'o5040, 12'h055, 12'o50, 0);
        step("R5 load", 1, oct_iot(4), 12'h000, 0, 0);
        step("R1 other device", 1, oct_iot(4, 3), 12'h033, 12'o10, 0);
        step("R7 fn3", 1, oct_iot(3), 12'h011, 0, 0);
        step("R7 fn5", 1, oct_iot(5), 12'h011, 0, 0);
        step("R7 fn7", 1, oct_iot(7), 12'h011, 0, 0);
        step("R10 clear beats accept", 1, oct_iot(2), 0, 0, 1);
        step("R5 load", 1, oct_iot(4), 12'h0A5, 0, 0);
        step("R10 load beats accept", 1, oct_iot(6), 12'h03C, 0, 1);
        step("R9 accept with test", 1, oct_iot(1), 0, 12'o4000, 1);
        step("R3 skip after accept", 1, oct_iot(1), 0, 12'o4000, 0);
        step("R4 clear", 1, oct_iot(2), 0, 0, 0);
        step("R4 idle after clear", 0, 0, 0, 0, 1);
        for (int k = 0; k < 40; k++)
            step("R1 sweep", 1, (k * 97) & 12'hFFF, k * 13, k * 211, k[0]);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule